// File: doc/BRIEF.md
# Three-Source Command Sequencer with Serial Microcommand Output

This block decides which of three command sources may drive the downstream controller, and turns each accepted command into an 8-bit serial microcommand. Commands come from three places: a 5-bit external command port qualified by a one-cycle sync strobe, a host-loaded command FIFO that can be replayed in order, and a host register that starts one command at a time. Only one source executes at any moment. The active source is reported as a two-bit mode tag and as two busy flags.

The host reaches the block through a small register window with four addresses. A control register holds a disable bit for the external port. The immediate-command register starts an immediate command or a FIFO replay. The status register carries busy, overrun and mode. The serial-rate register sets the speed of the serial clock. The host uses a safe handshake before touching other state. It first sets the disable bit. It then polls the busy flags until the command in progress has finished. Only then does it rewrite the serial rate.

Each microcommand carries the source tag in its two top bits, then an advance flag, then the 5-bit command code. It is shifted out on a command line with a qualifying serial clock.

Top module: `cmd_mode_ctrl`

## Requirements
- R1: After reset, both busy flags, the serial clock, the serial command line and the FIFO read strobe are 0. Address 0 (control), address 2 (status) and address 3 (serial rate) all read 0. Address 1 reads 0 at all times.
- R2: A microcommand is 8 bits long and is sent MSB first, one bit per rising edge of the serial clock. The serial clock idles low. Each half-period of the serial clock lasts (rate+1) master-clock cycles, so one command keeps its busy flag set for exactly 16*(rate+1) cycles after the edge that accepted it.
- R3: While idle and enabled, a sync pulse accepts the 5-bit command as the word {2'b01, advance, command}. The external/replay busy flag (status bit 0) is then set, and status bits [4:3] read 2'b01.
- R4: Writing a nonzero code other than 1 to address 1 while idle sends {2'b11, 1'b0, code}. The immediate busy flag (status bit 1) is then set, and status bits [4:3] read 2'b11.
- R5: Writing code 1 to address 1 while idle replays the FIFO. Each entry is sent in FIFO order as {2'b10, 1'b0, entry}, with one read strobe per entry. The replay ends when the FIFO is empty. Status bit 0 is set and bits [4:3] read 2'b10 during the replay. A replay of an empty FIFO sends nothing.
- R6: Bit 5 of address 0 disables the external port. While it is set, sync pulses are ignored and set no overrun. A command already in progress runs to completion.
- R7: An enabled external command that arrives while any command is executing is dropped and sets the sticky overrun bit (status bit 2). The bit is cleared only by writing 1 to bit 2 of address 2.
- R8: While either busy flag is set, writes to address 3 and writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cmd_i | input | 5 | External command code |
| ext_sync_i | input | 1 | One-cycle strobe qualifying ext_cmd_i |
| ext_adv_i | input | 1 | Advance-pipeline flag, sampled with the strobe |
| fifo_data_i | input | 5 | Head entry of the command FIFO (show-ahead) |
| fifo_empty_i | input | 1 | Command FIFO is empty |
| fifo_rd_o | output | 1 | Pops the FIFO head |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for host_addr_i (combinational) |
| busy_ext_o | output | 1 | External or replay command executing |
| busy_imm_o | output | 1 | Immediate command executing |
| ser_cmd_o | output | 1 | Serial microcommand bit |
| ser_clk_o | output | 1 | Serial clock qualifying ser_cmd_o |

## Verification
A sync pulse or host write sampled at edge E sets the matching busy flag and mode bits one sampling point later. The flag then stays up for exactly 16*(rate+1) edges. The bench measures from the falling edge after E and tests the flag at 16*(rate+1)-1 and 16*(rate+1) cycles. A separate monitor rebuilds each serial word from the line value at every rising serial clock, so word contents and word counts are checked independently of timing. Ignored stimuli (a disabled sync, a busy-time write) are checked after the block goes idle, by reading the register back and by confirming that the word count did not grow.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXT,
    ST_IMM,
    ST_EMU_FETCH,
    ST_EMU_RUN
  } cmc_state_e;

  localparam logic [1:0] TAG_NONE = 2'b00;
  localparam logic [1:0] TAG_EXT  = 2'b01;
  localparam logic [1:0] TAG_EMU  = 2'b10;
  localparam logic [1:0] TAG_IMM  = 2'b11;

  localparam int CTRL_DIS_BIT = 5;
  localparam int STAT_OVR_BIT = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_IMM  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_RATE = 2'd3;
endpackage

// File: rtl/cmc_serializer.sv
module cmc_serializer #(
  parameter int UC_W  = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [UC_W-1:0]  word_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sdat_o,
  output logic             sclk_o,
  output logic             done_o
);
  localparam int BIT_W = (UC_W > 1) ? $clog2(UC_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(UC_W - 1);

  logic             busy_q, busy_n;
  logic             ph_q, ph_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [UC_W-1:0]  sh_q, sh_n;

  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    done_o = 1'b0;
    if (busy_q) begin
      if (cnt_q == div_i) begin
        cnt_n = '0;
        if (!ph_q) begin
          ph_n = 1'b1;
        end else begin
          ph_n = 1'b0;
          sh_n = {sh_q[UC_W-2:0], 1'b0};
          if (bit_q == LAST_BIT) begin
            busy_n = 1'b0;
            done_o = 1'b1;
          end else begin
            bit_n = bit_q + 1'b1;
          end
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_n = 1'b1;
      ph_n   = 1'b0;
      cnt_n  = '0;
      bit_n  = '0;
      sh_n   = word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
    end
  end

  assign sclk_o = busy_q & ph_q;
  assign sdat_o = busy_q & sh_q[UC_W-1];
endmodule

// File: rtl/cmc_arbiter.sv
module cmc_arbiter
  import cmc_pkg::*;
#(
  parameter int CMD_W = 5,
  parameter int UC_W  = CMD_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sync_i,
  input  logic             ext_adv_i,
  input  logic [CMD_W-1:0] ext_cmd_i,
  input  logic             ext_dis_i,
  input  logic             imm_go_i,
  input  logic [CMD_W-1:0] imm_code_i,
  input  logic             fifo_empty_i,
  input  logic [CMD_W-1:0] fifo_data_i,
  input  logic             ser_done_i,
  output logic             fifo_rd_o,
  output logic             ser_start_o,
  output logic [UC_W-1:0]  ser_word_o,
  output logic             busy_ext_o,
  output logic             busy_imm_o,
  output logic [1:0]       mode_tag_o,
  output logic             ovr_set_o
);
  localparam logic [CMD_W-1:0] CODE_REPLAY = CMD_W'(1);

  cmc_state_e state_q, state_n;
  logic       accept;

  assign accept = ext_sync_i & ~ext_dis_i;

  always_comb begin
    state_n     = state_q;
    fifo_rd_o   = 1'b0;
    ser_start_o = 1'b0;
    ser_word_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          ser_start_o = 1'b1;
          ser_word_o  = {TAG_EXT, ext_adv_i, ext_cmd_i};
          state_n     = ST_EXT;
        end else if (imm_go_i) begin
          if (imm_code_i == CODE_REPLAY) begin
            state_n = ST_EMU_FETCH;
          end else begin
            ser_start_o = 1'b1;
            ser_word_o  = {TAG_IMM, 1'b0, imm_code_i};
            state_n     = ST_IMM;
          end
        end
      end
      ST_EXT, ST_IMM: begin
        if (ser_done_i) state_n = ST_IDLE;
      end
      ST_EMU_FETCH: begin
        if (fifo_empty_i) begin
          state_n = ST_IDLE;
        end else begin
          fifo_rd_o   = 1'b1;
          ser_start_o = 1'b1;
          ser_word_o  = {TAG_EMU, 1'b0, fifo_data_i};
          state_n     = ST_EMU_RUN;
        end
      end
      ST_EMU_RUN: begin
        if (ser_done_i) state_n = ST_EMU_FETCH;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  always_comb begin
    busy_ext_o = 1'b0;
    busy_imm_o = 1'b0;
    mode_tag_o = TAG_NONE;
    unique case (state_q)
      ST_EXT: begin
        busy_ext_o = 1'b1;
        mode_tag_o = TAG_EXT;
      end
      ST_EMU_FETCH, ST_EMU_RUN: begin
        busy_ext_o = 1'b1;
        mode_tag_o = TAG_EMU;
      end
      ST_IMM: begin
        busy_imm_o = 1'b1;
        mode_tag_o = TAG_IMM;
      end
      default: ;
    endcase
  end

  assign ovr_set_o = accept & (state_q != ST_IDLE);
endmodule

// File: rtl/cmc_host_regs.sv
module cmc_host_regs
  import cmc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 5,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_ext_i,
  input  logic              busy_imm_i,
  input  logic [1:0]        mode_tag_i,
  input  logic              ovr_set_i,
  output logic              ext_dis_o,
  output logic              imm_go_o,
  output logic [CMD_W-1:0]  imm_code_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              ovr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic              ovr_q, ovr_n;
  logic              busy_any;

  assign busy_any = busy_ext_i | busy_imm_i;

  always_comb begin
    ctrl_n = ctrl_q;
    div_n  = div_q;
    ovr_n  = ovr_q;
    if (wr_i && addr_i == ADDR_CTRL) ctrl_n = wdata_i;
    if (wr_i && addr_i == ADDR_RATE && !busy_any) div_n = wdata_i[DIV_W-1:0];
    if (wr_i && addr_i == ADDR_STAT && wdata_i[STAT_OVR_BIT]) ovr_n = 1'b0;
    if (ovr_set_i) ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      div_q  <= div_n;
      ovr_q  <= ovr_n;
    end
  end

  assign imm_code_o = wdata_i[CMD_W-1:0];
  assign imm_go_o   = wr_i && (addr_i == ADDR_IMM) && (wdata_i[CMD_W-1:0] != '0);
  assign ext_dis_o  = ctrl_q[CTRL_DIS_BIT];
  assign div_o      = div_q;
  assign ovr_o      = ovr_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_IMM:  rdata_o = '0;
      ADDR_STAT: begin
        rdata_o[0]            = busy_ext_i;
        rdata_o[1]            = busy_imm_i;
        rdata_o[STAT_OVR_BIT] = ovr_q;
        rdata_o[4:3]          = mode_tag_i;
      end
      ADDR_RATE: rdata_o[DIV_W-1:0] = div_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmd_mode_ctrl.sv
module cmd_mode_ctrl #(
  parameter int CMD_W  = 5,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  ext_cmd_i,
  input  logic              ext_sync_i,
  input  logic              ext_adv_i,
  input  logic [CMD_W-1:0]  fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_rd_o,
  input  logic              host_wr_i,
  input  logic [1:0]        host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              busy_ext_o,
  output logic              busy_imm_o,
  output logic              ser_cmd_o,
  output logic              ser_clk_o
);
  localparam int UC_W = CMD_W + 3;

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             ext_dis, imm_go, ovr_set, ovr_q, ser_start, ser_done;
  logic [CMD_W-1:0] imm_code;
  logic [DIV_W-1:0] div;
  logic [UC_W-1:0]  ser_word;
  logic [1:0]       mode_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  cmc_host_regs #(.DATA_W(DATA_W), .CMD_W(CMD_W), .DIV_W(DIV_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_i       (host_wr_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .busy_ext_i (busy_ext_o),
    .busy_imm_i (busy_imm_o),
    .mode_tag_i (mode_tag),
    .ovr_set_i  (ovr_set),
    .ext_dis_o  (ext_dis),
    .imm_go_o   (imm_go),
    .imm_code_o (imm_code),
    .div_o      (div),
    .ovr_o      (ovr_q),
    .rdata_o    (host_rdata_o)
  );

  cmc_arbiter #(.CMD_W(CMD_W), .UC_W(UC_W)) arb_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .ext_sync_i   (ext_sync_i),
    .ext_adv_i    (ext_adv_i),
    .ext_cmd_i    (ext_cmd_i),
    .ext_dis_i    (ext_dis),
    .imm_go_i     (imm_go),
    .imm_code_i   (imm_code),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .ser_done_i   (ser_done),
    .fifo_rd_o    (fifo_rd_o),
    .ser_start_o  (ser_start),
    .ser_word_o   (ser_word),
    .busy_ext_o   (busy_ext_o),
    .busy_imm_o   (busy_imm_o),
    .mode_tag_o   (mode_tag),
    .ovr_set_o    (ovr_set)
  );

  cmc_serializer #(.UC_W(UC_W), .DIV_W(DIV_W)) ser_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (ser_start),
    .word_i  (ser_word),
    .div_i   (div),
    .sdat_o  (ser_cmd_o),
    .sclk_o  (ser_clk_o),
    .done_o  (ser_done)
  );
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_sync,
  input logic       ext_dis,
  input logic       ovr,
  input logic       host_wr,
  input logic [1:0] host_addr,
  input logic       clr_bit,
  input logic       busy_ext,
  input logic       busy_imm,
  input logic       ser_clk,
  input logic       ser_cmd,
  input logic       fifo_rd,
  input logic       fifo_empty
);
  assert_sclk_in_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> (busy_ext || busy_imm));

  assert_bit_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_cmd));

  assert_one_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_ext && busy_imm));

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (!fifo_empty && busy_ext && !busy_imm));

  assert_disabled_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sync && ext_dis && !busy_ext && !busy_imm && !(host_wr && host_addr == 2'd1))
      |=> (!busy_ext && !busy_imm));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(host_wr && host_addr == 2'd2 && clr_bit)) |=> ovr);
endmodule

bind cmd_mode_ctrl cmc_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_sync   (ext_sync_i),
  .ext_dis    (ext_dis),
  .ovr        (ovr_q),
  .host_wr    (host_wr_i),
  .host_addr  (host_addr_i),
  .clr_bit    (host_wdata_i[2]),
  .busy_ext   (busy_ext_o),
  .busy_imm   (busy_imm_o),
  .ser_clk    (ser_clk_o),
  .ser_cmd    (ser_cmd_o),
  .fifo_rd    (fifo_rd_o),
  .fifo_empty (fifo_empty_i)
);

// File: tb/cmd_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmd_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] ext_cmd;
  logic       ext_sync, ext_adv;
  logic [4:0] fifo_data;
  logic       fifo_empty, fifo_rd;
  logic       host_wr;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       busy_ext, busy_imm, ser_cmd, ser_clk;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cmd_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .ext_cmd_i(ext_cmd), .ext_sync_i(ext_sync), .ext_adv_i(ext_adv),
    .fifo_data_i(fifo_data), .fifo_empty_i(fifo_empty), .fifo_rd_o(fifo_rd),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .busy_ext_o(busy_ext), .busy_imm_o(busy_imm),
    .ser_cmd_o(ser_cmd), .ser_clk_o(ser_clk)
  );

  // Show-ahead FIFO model
  logic [4:0] fmem [0:15];
  int rp = 0;
  int wp = 0;
  assign fifo_empty = (rp == wp);
  assign fifo_data  = fmem[rp[3:0]];
  always @(posedge clk) if (fifo_rd) rp <= rp + 1;

  // Serial word collector
  logic [7:0] got [0:63];
  logic [7:0] acc = 8'h00;
  int  nbits = 0;
  int  nw = 0;
  logic prev_sclk = 1'b0;
  always @(posedge clk) begin
    if (ser_clk && !prev_sclk) begin
      acc = {acc[6:0], ser_cmd};
      nbits++;
      if (nbits == 8) begin
        got[nw[5:0]] = acc;
        nw++;
        nbits = 0;
      end
    end
    prev_sclk = ser_clk;
  end

  function automatic logic [7:0] uc(input logic [1:0] tag, input logic adv, input logic [4:0] c);
    return {tag, adv, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    host_addr = a;
    #0.5;
    v = host_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pulse_ext(input logic [4:0] c, input logic adv);
    ext_cmd = c; ext_adv = adv; ext_sync = 1'b1;
    @(negedge clk);
    ext_sync = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (!busy_ext && !busy_imm) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 busy_ext", busy_ext, 0);
    chk("R1 busy_imm", busy_imm, 0);
    chk("R1 ser_clk", ser_clk, 0);
    chk("R1 ser_cmd", ser_cmd, 0);
    chk("R1 fifo_rd", fifo_rd, 0);
    rd_reg(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 imm reg", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 status", v, 8'h00);
    rd_reg(2'd3, v); chk("R1 rate", v, 8'h00);
  endtask

  task automatic t_external();
    logic [7:0] v;
    int n0 = nw;
    pulse_ext(5'h13, 1'b1);
    chk("R3 busy_ext set", busy_ext, 1);
    rd_reg(2'd2, v); chk("R3 status mode ext", v, 8'h09);
    wait_cyc(15);
    chk("R2 busy at 16-1", busy_ext, 1);
    wait_cyc(1);
    chk("R2 busy clear at 16", busy_ext, 0);
    chk("R3 word count", nw, n0 + 1);
    chk("R3 word adv=1", got[n0], uc(2'b01, 1'b1, 5'h13));
    pulse_ext(5'h05, 1'b0);
    wait_idle();
    chk("R3 word adv=0", got[n0+1], uc(2'b01, 1'b0, 5'h05));
  endtask

  task automatic t_immediate();
    logic [7:0] v;
    int n0 = nw;
    wr_reg(2'd1, 8'h0A);
    chk("R4 busy_imm set", busy_imm, 1);
    rd_reg(2'd2, v); chk("R4 status mode imm", v, 8'h1A);
    wait_idle();
    chk("R4 word", got[n0], uc(2'b11, 1'b0, 5'h0A));
    chk("R4 word count", nw, n0 + 1);
  endtask

  task automatic t_emulation();
    logic [7:0] v;
    int n0 = nw;
    fmem[wp[3:0]] = 5'h03; wp++;
    fmem[wp[3:0]] = 5'h1F; wp++;
    fmem[wp[3:0]] = 5'h00; wp++;
    wr_reg(2'd1, 8'h01);
    chk("R5 busy_ext during replay", busy_ext, 1);
    rd_reg(2'd2, v); chk("R5 status mode replay", v, 8'h11);
    wait_idle();
    chk("R5 word count", nw, n0 + 3);
    chk("R5 word 0", got[n0], uc(2'b10, 1'b0, 5'h03));
    chk("R5 word 1", got[n0+1], uc(2'b10, 1'b0, 5'h1F));
    chk("R5 word 2", got[n0+2], uc(2'b10, 1'b0, 5'h00));
    chk("R5 fifo drained", fifo_empty, 1);
    wr_reg(2'd1, 8'h01);
    wait_idle();
    wait_cyc(20);
    chk("R5 empty replay sends nothing", nw, n0 + 3);
    chk("R5 empty replay idle", busy_ext, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    int n0 = nw;
    wr_reg(2'd1, 8'h04);
    pulse_ext(5'h1E, 1'b0);
    wait_idle();
    wait_cyc(2);
    chk("R7 dropped command", nw, n0 + 1);
    chk("R7 running word intact", got[n0], uc(2'b11, 1'b0, 5'h04));
    rd_reg(2'd2, v); chk("R7 overrun sticky", v, 8'h04);
    wr_reg(2'd2, 8'h04);
    rd_reg(2'd2, v); chk("R7 overrun cleared", v, 8'h00);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    int n0 = nw;
    pulse_ext(5'h11, 1'b0);
    wait_cyc(3);
    wr_reg(2'd0, 8'h20);
    chk("R6 in-progress still busy", busy_ext, 1);
    wait_idle();
    chk("R6 in-progress completes", got[n0], uc(2'b01, 1'b0, 5'h11));
    pulse_ext(5'h02, 1'b0);
    chk("R6 disabled not busy", busy_ext, 0);
    wait_cyc(20);
    chk("R6 disabled no word", nw, n0 + 1);
    rd_reg(2'd2, v); chk("R6 disabled no overrun", v, 8'h00);
    rd_reg(2'd0, v); chk("R6 ctrl readback", v, 8'h20);
    wr_reg(2'd0, 8'h00);
    pulse_ext(5'h02, 1'b1);
    wait_idle();
    chk("R6 re-enabled accepts", got[n0+1], uc(2'b01, 1'b1, 5'h02));
  endtask

  task automatic t_gated();
    logic [7:0] v;
    int n0 = nw;
    wr_reg(2'd1, 8'h06);
    wr_reg(2'd3, 8'h05);
    wr_reg(2'd1, 8'h07);
    wait_idle();
    wait_cyc(2);
    rd_reg(2'd3, v); chk("R8 rate write ignored while busy", v, 8'h00);
    chk("R8 immediate ignored while busy", nw, n0 + 1);
    chk("R8 running word", got[n0], uc(2'b11, 1'b0, 5'h06));
    wr_reg(2'd3, 8'h02);
    rd_reg(2'd3, v); chk("R8 rate write while idle", v, 8'h02);
  endtask

  task automatic t_rate();
    int n0 = nw;
    pulse_ext(5'h0F, 1'b1);
    wait_cyc(47);
    chk("R2 rate 2 busy at 48-1", busy_ext, 1);
    wait_cyc(1);
    chk("R2 rate 2 busy clear at 48", busy_ext, 0);
    chk("R2 rate 2 word", got[n0], uc(2'b01, 1'b1, 5'h0F));
    wr_reg(2'd3, 8'h00);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_cmd = '0; ext_sync = 1'b0; ext_adv = 1'b0;
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_external();
    t_immediate();
    t_emulation();
    t_overrun();
    t_disable();
    t_gated();
    t_rate();
    summary();
    $finish;
  end
endmodule